// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block owns the program counter of a 32-bit RISC-style fetch stage and chooses, every clock, the address to fetch next. A decoder in front of it supplies a two-bit control class, a condition result that has already been evaluated, a 16-bit branch displacement, a 26-bit jump index, a register operand and a destination register number. The block registers the chosen address as the new PC on each rising edge. A synchronous reset loads a configurable reset vector.

Alongside the address, the block produces the register write that linking instructions need. The return address skips one delay slot, so it is the current PC plus 8. It goes to register 31 for branches and absolute jumps. It goes to the instruction's destination register for the register-indirect form. A write aimed at register 0 is dropped. The link outputs are combinational in the current PC and the current inputs, so the register file can take them in the same cycle.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes `RESET_VEC` after that edge.
- R2: With `ctrl_i` = 2'b00 (sequential), the next `pc_o` is `pc_o` + 4.
- R3: With `ctrl_i` = 2'b01 (conditional branch) and `taken_i` low, the next `pc_o` is `pc_o` + 4.
- R4: With `ctrl_i` = 2'b01 and `taken_i` high, the next `pc_o` is computed as follows. Shift `off_i` left by two, sign-extend that 18-bit value from its bit 17 (the offset's bit 15), and add it to `pc_o` + 4.
- R5: With `ctrl_i` = 2'b10 (absolute jump), the next `pc_o` is built from three parts, most significant first: bits 31:28 of `pc_o` + 4, then `idx_i`, then two zero bits.
- R6: With `ctrl_i` = 2'b11 (register-indirect jump), the next `pc_o` is `rs_val_i` unchanged.
- R7: When `link_i` is high and `ctrl_i` is 2'b01 or 2'b10, `link_we_o` is high and `link_idx_o` is 31. This holds whether or not a branch is taken.
- R8: When `link_i` is high and `ctrl_i` is 2'b11, `link_idx_o` equals `dst_i`.
- R9: `link_we_o` is low in three cases: when `link_i` is low, when `ctrl_i` is 2'b00, and when the link index would be 0.
- R10: Whenever `link_we_o` is high, `link_val_o` equals `pc_o` + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_i | input | 2 | Control class: 00 sequential, 01 branch, 10 absolute jump, 11 register jump |
| taken_i | input | 1 | Branch condition result |
| off_i | input | 16 | Signed branch displacement in words |
| idx_i | input | 26 | Absolute jump word index |
| rs_val_i | input | 32 | Register operand, target of register-indirect jump |
| dst_i | input | 5 | Link destination for the register-indirect form |
| link_i | input | 1 | Instruction requests a return-address write |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address destination register |
| link_val_o | output | 32 | Return address |

## Verification
The bound checker tests the following on every cycle: each control class against the PC one edge later, the branch target arithmetic, the fixed link destination, the suppression of writes to register 0, and the return-address value. Some behaviour only the bench's scenarios can show. These are the reset vector after reset, extreme displacements at both ends of the signed range, the top-nibble splice of an absolute jump across a 256 MB boundary, and long mixed streams where a wrong PC would carry into later targets.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        CF_SEQ  = 2'b00,
        CF_BR   = 2'b01,
        CF_JABS = 2'b10,
        CF_JREG = 2'b11
    } ctrl_e;

    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/npc_target.sv
module npc_target #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned OFFW = 16,
    parameter int unsigned IDXW = 26
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [OFFW-1:0] off_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [XLEN-1:0] seq_o,
    output logic [XLEN-1:0] br_o,
    output logic [XLEN-1:0] jabs_o
);
    import npc_pkg::*;

    localparam int unsigned EXTW = XLEN - OFFW - WORD_SHIFT;
    localparam int unsigned HIW  = XLEN - IDXW - WORD_SHIFT;

    logic [XLEN-1:0] disp;

    always_comb begin
        seq_o  = pc_i + XLEN'(INSN_BYTES);
        disp   = {{EXTW{off_i[OFFW-1]}}, off_i, {WORD_SHIFT{1'b0}}};
        br_o   = seq_o + disp;
        jabs_o = {seq_o[XLEN-1 -: HIW], idx_i, {WORD_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/npc_link.sv
module npc_link #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned REGW     = 5,
    parameter int unsigned LINK_REG = 31
) (
    input  npc_pkg::ctrl_e  ctrl_i,
    input  logic            link_i,
    input  logic [REGW-1:0] dst_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            we_o,
    output logic [REGW-1:0] idx_o,
    output logic [XLEN-1:0] val_o
);
    import npc_pkg::*;

    localparam int unsigned RET_BYTES = 2 * INSN_BYTES;

    always_comb begin
        idx_o = (ctrl_i == CF_JREG) ? dst_i : REGW'(LINK_REG);
        we_o  = link_i && (ctrl_i != CF_SEQ) && (idx_o != '0);
        val_o = pc_i + XLEN'(RET_BYTES);
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int unsigned    XLEN      = 32,
    parameter int unsigned    OFFW      = 16,
    parameter int unsigned    IDXW      = 26,
    parameter int unsigned    REGW      = 5,
    parameter int unsigned    LINK_REG  = 31,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      ctrl_i,
    input  logic            taken_i,
    input  logic [OFFW-1:0] off_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [REGW-1:0] dst_i,
    input  logic            link_i,
    output logic [XLEN-1:0] pc_o,
    output logic            link_we_o,
    output logic [REGW-1:0] link_idx_o,
    output logic [XLEN-1:0] link_val_o
);
    import npc_pkg::*;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t state_d, state_q;
    ctrl_e  ctrl;

    logic [XLEN-1:0] seq_tgt, br_tgt, jabs_tgt;

    assign ctrl = ctrl_e'(ctrl_i);

    npc_target #(
        .XLEN (XLEN),
        .OFFW (OFFW),
        .IDXW (IDXW)
    ) u_target (
        .pc_i   (state_q.pc),
        .off_i  (off_i),
        .idx_i  (idx_i),
        .seq_o  (seq_tgt),
        .br_o   (br_tgt),
        .jabs_o (jabs_tgt)
    );

    npc_link #(
        .XLEN     (XLEN),
        .REGW     (REGW),
        .LINK_REG (LINK_REG)
    ) u_link (
        .ctrl_i (ctrl),
        .link_i (link_i),
        .dst_i  (dst_i),
        .pc_i   (state_q.pc),
        .we_o   (link_we_o),
        .idx_o  (link_idx_o),
        .val_o  (link_val_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (ctrl)
            CF_SEQ:  state_d.pc = seq_tgt;
            CF_BR:   state_d.pc = taken_i ? br_tgt : seq_tgt;
            CF_JABS: state_d.pc = jabs_tgt;
            CF_JREG: state_d.pc = rs_val_i;
            default: state_d.pc = seq_tgt;
        endcase
        if (rst) begin
            state_d.pc = RESET_VEC;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_o = state_q.pc;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned OFFW     = 16,
    parameter int unsigned IDXW     = 26,
    parameter int unsigned REGW     = 5,
    parameter int unsigned LINK_REG = 31
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      ctrl_i,
    input logic            taken_i,
    input logic [OFFW-1:0] off_i,
    input logic [IDXW-1:0] idx_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [REGW-1:0] dst_i,
    input logic            link_i,
    input logic [XLEN-1:0] pc_o,
    input logic            link_we_o,
    input logic [REGW-1:0] link_idx_o,
    input logic [XLEN-1:0] link_val_o
);
    localparam int unsigned EXTW = XLEN - OFFW - 2;
    localparam int unsigned HIW  = XLEN - IDXW - 2;

    logic [XLEN-1:0] disp, pc4;
    assign disp = {{EXTW{off_i[OFFW-1]}}, off_i, 2'b00};
    assign pc4  = pc_o + XLEN'(4);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i == 2'b00) |=> (pc_o == $past(pc4)));

    // R3
    br_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i == 2'b01 && !taken_i) |=> (pc_o == $past(pc4)));

    // R4
    br_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i == 2'b01 && taken_i) |=> (pc_o == $past(pc4) + $past(disp)));

    // R5
    jabs_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i == 2'b10) |=>
        (pc_o == {$past(pc4[XLEN-1 -: HIW]), $past(idx_i), 2'b00}));

    // R6
    jreg_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i == 2'b11) |=> (pc_o == $past(rs_val_i)));

    // R7
    fixed_link_chk: assert property (@(posedge clk) disable iff (rst)
        (link_i && (ctrl_i == 2'b01 || ctrl_i == 2'b10)) |->
        (link_we_o && link_idx_o == REGW'(LINK_REG)));

    // R8
    jreg_link_chk: assert property (@(posedge clk) disable iff (rst)
        (link_i && ctrl_i == 2'b11) |-> (link_idx_o == dst_i));

    // R9
    no_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_i && ctrl_i != 2'b00 && link_idx_o != '0));

    // R10
    ret_addr_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_val_o == pc_o + XLEN'(8)));

endmodule

bind npc_unit npc_unit_chk #(
    .XLEN     (XLEN),
    .OFFW     (OFFW),
    .IDXW     (IDXW),
    .REGW     (REGW),
    .LINK_REG (LINK_REG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_i     (ctrl_i),
    .taken_i    (taken_i),
    .off_i      (off_i),
    .idx_i      (idx_i),
    .rs_val_i   (rs_val_i),
    .dst_i      (dst_i),
    .link_i     (link_i),
    .pc_o       (pc_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

    localparam logic [31:0] RV = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ctrl_i = 2'b00;
    logic        taken_i = 1'b0;
    logic [15:0] off_i = '0;
    logic [25:0] idx_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [4:0]  dst_i = '0;
    logic        link_i = 1'b0;
    logic [31:0] pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_val_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] mpc;

    always #10 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .ctrl_i     (ctrl_i),
        .taken_i    (taken_i),
        .off_i      (off_i),
        .idx_i      (idx_i),
        .rs_val_i   (rs_val_i),
        .dst_i      (dst_i),
        .link_i     (link_i),
        .pc_o       (pc_o),
        .link_we_o  (link_we_o),
        .link_idx_o (link_idx_o),
        .link_val_o (link_val_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1", pc_o, RV);
        mpc = RV;
    endtask

    task automatic step(input logic [1:0] c, input logic t, input logic [15:0] o,
                        input logic [25:0] x, input logic [31:0] r,
                        input logic [4:0] d, input logic l);
        logic [31:0] pc4, nxt;
        logic [4:0]  li;
        logic        we;
        string       rq;
        @(negedge clk);
        rst = 1'b0; ctrl_i = c; taken_i = t; off_i = o;
        idx_i = x; rs_val_i = r; dst_i = d; link_i = l;
        #1;
        pc4 = mpc + 32'd4;
        case (c)
            2'b00: begin nxt = pc4; rq = "R2"; end
            2'b01: begin
                nxt = t ? pc4 + {{14{o[15]}}, o, 2'b00} : pc4;
                rq  = t ? "R4" : "R3";
            end
            2'b10: begin nxt = {pc4[31:28], x, 2'b00}; rq = "R5"; end
            default: begin nxt = r; rq = "R6"; end
        endcase
        li = (c == 2'b11) ? d : 5'd31;
        we = l && (c != 2'b00) && (li != 5'd0);
        chk("R9", {31'd0, link_we_o}, {31'd0, we});
        if (we) begin
            chk((c == 2'b11) ? "R8" : "R7", {27'd0, link_idx_o}, {27'd0, li});
            chk("R10", link_val_o, mpc + 32'd8);
        end
        @(posedge clk);
        #2;
        chk(rq, pc_o, nxt);
        mpc = nxt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        mpc = RV;
        repeat (2) @(posedge clk);
        do_reset();
        // R2 sequential
        step(2'b00, 0, 16'h0000, 26'h0, 32'h0, 5'd0, 0);
        step(2'b00, 0, 16'h0000, 26'h0, 32'h0, 5'd0, 0);
        // R4 forward, backward, most negative, most positive displacement
        step(2'b01, 1, 16'h0010, 26'h0, 32'h0, 5'd0, 0);
        step(2'b01, 1, 16'hFFFC, 26'h0, 32'h0, 5'd0, 0);
        step(2'b01, 1, 16'h8000, 26'h0, 32'h0, 5'd0, 0);
        step(2'b01, 1, 16'h7FFF, 26'h0, 32'h0, 5'd0, 0);
        // R3 not taken, with R7 link anyway
        step(2'b01, 0, 16'h0100, 26'h0, 32'h0, 5'd0, 1);
        // R5 absolute jumps, R7 link
        step(2'b10, 0, 16'h0, 26'h3FF_FFFF, 32'h0, 5'd0, 0);
        step(2'b10, 0, 16'h0, 26'h000_0040, 32'h0, 5'd0, 1);
        // R6 / R8 register jump with link to r5
        step(2'b11, 0, 16'h0, 26'h0, 32'h8FFF_FFFC, 5'd5, 1);
        // R5 across a 256 MB boundary from 0x8FFF_FFFC
        step(2'b10, 0, 16'h0, 26'h000_1234, 32'h0, 5'd0, 0);
        // R9 link to r0 suppressed, sequential link ignored
        step(2'b11, 0, 16'h0, 26'h0, 32'h0040_0000, 5'd0, 1);
        step(2'b00, 0, 16'h0, 26'h0, 32'h0, 5'd9, 1);
        step(2'b01, 1, 16'h0002, 26'h0, 32'h0, 5'd0, 1);
        // R1 mid-run reset
        do_reset();
        for (int i = 0; i < 400; i++) begin
            step(2'($urandom), 1'($urandom), 16'($urandom), 26'($urandom),
                 $urandom, 5'($urandom), 1'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule